// File: doc/BRIEF.md
# PHY Management Interrupt Controller

This block gathers nine single-cycle event pulses from a PHY datapath and keeps each one in a sticky pending bit. A per-source enable register chooses which pending bits may pull a shared active-low interrupt line. The line is open-drain, so several devices can share one wire as a wired OR.

Both registers sit behind a small register port, so a management-bus front end can attach directly. The port has an address, write data, a write strobe, a read strobe and registered read data. The enable register lives at index 24 and the pending register at index 25.

Reading index 25 returns the pending bits and clears them in the same cycle. An event that lands in that same cycle survives the clear. The pad is modelled as an output enable plus a constant low drive value. The pull-up resistor and the logic that produces the events are outside this block.

Top module: `phy_irq_ctrl`

The line driver is a two-state machine:
- LINE_RELEASED: the output enable is low. It moves to LINE_DRIVEN when any pending bit is also enabled.
- LINE_DRIVEN: the output enable is high. It returns to LINE_RELEASED when no enabled bit is pending.

## Requirements
- R1: After reset the enable register, the pending register, the read data and the output enable are all zero.
- R2: A write to index 24 stores write-data bits 8:0 as the enable bits. A read of index 24 returns them in bits 8:0, with bits 15:9 as zero.
- R3: A pending bit, once set, stays set until a read of index 25 clears it. Events on other bits and changes to the enable register do not clear it.
- R4: Event input bit i sets pending bit i, whatever the enable bits hold. The bit order is:
  - bit 0: autonegotiation state change
  - bit 1: autonegotiation page arrival
  - bit 2: FIFO over/underrun
  - bit 3: link change
  - bit 4: CRC error
  - bit 5: error counter full
  - bit 6: local/remote receive state change
  - bit 7: speed downshift
  - bit 8: management sync loss
- R5: A read strobe is sampled at a clock edge. From that edge on, reg_rdata_o holds the addressed value, and it keeps it until the next read. A read of index 25 returns the pending bits in 8:0, with zeros above, and clears every pending bit at that same edge.
- R6: An event sampled at the same edge as a read of index 25 is not part of the returned value. It stays pending after the clear.
- R7: After each clock edge, irq_oe_o equals the OR of (pending AND enable) as it stood after the previous edge. An event sampled at edge k therefore drives the line from edge k+1.
- R8: irq_pad_o is always low. The line is driven only through irq_oe_o.
- R9: Writes to index 25 or to any other index except 24 change no state. Reads of any index except 24 and 25 return zero.
- R10: Changing only the enable register asserts or releases the line according to R7, and leaves the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 9 | Event pulses, one per source, in the R4 order |
| reg_addr_i | input | 5 | Register index |
| reg_wdata_i | input | 16 | Write data |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 16 | Registered read data |
| irq_oe_o | output | 1 | Pad output enable; high means the line is pulled low |
| irq_pad_o | output | 1 | Pad drive value, constant low |

## Verification
Each kind of internal fault shows at the ports within a few cycles:
- A stuck or lost pending bit appears in the very next read of index 25. It also shows one edge later on irq_oe_o when its enable bit is set.
- A wrong enable bit shows in the read-back of index 24, and in the line state one edge after any pending bit meets it.
- A clear that wins over a coincident event, or a read that fails to clear, shows in the second of two back-to-back reads.
- A line state machine that lags or leads shows as an irq_oe_o mismatch at the edge where R7 fixes its value.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int NUM_SRC  = 9;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 5;
    localparam int MASK_IDX = 24;
    localparam int STAT_IDX = 25;

    // Bit position of each event source in both registers.
    typedef enum logic [3:0] {
        SRC_ANEG_STATE = 4'd0,
        SRC_ANEG_PAGE  = 4'd1,
        SRC_FIFO_ERR   = 4'd2,
        SRC_LINK_CHG   = 4'd3,
        SRC_CRC_ERR    = 4'd4,
        SRC_CNT_FULL   = 4'd5,
        SRC_RXSTAT_CHG = 4'd6,
        SRC_DOWNSHIFT  = 4'd7,
        SRC_SYNC_LOSS  = 4'd8
    } irq_src_e;

    typedef enum logic {
        LINE_RELEASED = 1'b0,
        LINE_DRIVEN   = 1'b1
    } line_state_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int N = phy_irq_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] status_o
);

    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (evt_i[g]) begin
                pend_q[g] <= 1'b1;
            end else if (clr_i) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    assign status_o = pend_q;

    // R3: without a clear, no set bit drops
    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R6: an event always leaves its bit set, even against a clear
    a_r6_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

    // R5: a clear with no event empties the bank
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i == '0) |=> (pend_q == '0));

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile #(
    parameter int N        = phy_irq_pkg::NUM_SRC,
    parameter int REG_W    = phy_irq_pkg::REG_W,
    parameter int ADDR_W   = phy_irq_pkg::ADDR_W,
    parameter int MASK_IDX = phy_irq_pkg::MASK_IDX,
    parameter int STAT_IDX = phy_irq_pkg::STAT_IDX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [N-1:0]      status_i,
    output logic [N-1:0]      mask_o,
    output logic [REG_W-1:0]  rdata_o,
    output logic              stat_clr_o
);

    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_IDX);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);

    logic [N-1:0]     mask_q;
    logic [REG_W-1:0] rdata_q;
    logic [REG_W-1:0] rsel;
    logic             hit_mask;
    logic             hit_stat;

    assign hit_mask = (addr_i == MASK_A);
    assign hit_stat = (addr_i == STAT_A);

    always_comb begin
        rsel = '0;
        if (hit_mask) begin
            rsel[N-1:0] = mask_q;
        end else if (hit_stat) begin
            rsel[N-1:0] = status_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_i && hit_mask) begin
            mask_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rsel;
        end
    end

    assign stat_clr_o = rd_i && hit_stat;
    assign mask_o     = mask_q;
    assign rdata_o    = rdata_q;

    // R9: unmapped reads return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !hit_mask && !hit_stat) |=> (rdata_o == '0));

    // R2: a write to the enable index takes effect at the next edge
    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && hit_mask) |=> (mask_o == $past(wdata_i)));

    // R9: no other write touches the enable bits
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && hit_mask) |=> $stable(mask_o));

    // R5: read data holds between reads
    a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm #(
    parameter int N = phy_irq_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status_i,
    input  logic [N-1:0] mask_i,
    output logic         oe_o,
    output logic         pad_o
);
    import phy_irq_pkg::*;

    line_state_e state_q;
    line_state_e state_d;
    logic        pending;

    assign pending = |(status_i & mask_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_RELEASED: if (pending)  state_d = LINE_DRIVEN;
            LINE_DRIVEN:   if (!pending) state_d = LINE_RELEASED;
            default:       state_d = LINE_RELEASED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_RELEASED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        oe_o  = 1'b0;
        pad_o = 1'b0;
        unique case (state_q)
            LINE_RELEASED: oe_o = 1'b0;
            LINE_DRIVEN:   oe_o = 1'b1;
            default:       oe_o = 1'b0;
        endcase
    end

    // R7: line asserts only for an enabled pending bit, one edge later
    a_r7_oe_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(pending));

    // R7: line releases one edge after nothing enabled is pending
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !oe_o);

endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl #(
    parameter int NUM_SRC  = phy_irq_pkg::NUM_SRC,
    parameter int REG_W    = phy_irq_pkg::REG_W,
    parameter int ADDR_W   = phy_irq_pkg::ADDR_W,
    parameter int MASK_IDX = phy_irq_pkg::MASK_IDX,
    parameter int STAT_IDX = phy_irq_pkg::STAT_IDX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               irq_oe_o,
    output logic               irq_pad_o
);

    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic               stat_clr;
    logic               wdata_unused;

    assign wdata_unused = ^reg_wdata_i[REG_W-1:NUM_SRC];

    irq_status_bank #(.N(NUM_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (stat_clr),
        .status_o (status)
    );

    irq_regfile #(
        .N        (NUM_SRC),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .MASK_IDX (MASK_IDX),
        .STAT_IDX (STAT_IDX)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i[NUM_SRC-1:0]),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .status_i   (status),
        .mask_o     (mask),
        .rdata_o    (reg_rdata_o),
        .stat_clr_o (stat_clr)
    );

    irq_line_fsm #(.N(NUM_SRC)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .mask_i   (mask),
        .oe_o     (irq_oe_o),
        .pad_o    (irq_pad_o)
    );

    // R10: enable changes never alter pending bits (no clear, no event)
    a_r10_mask_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clr && evt_i == '0) |=> $stable(status));

    // R8: pad value stays low whenever the line is driven
    a_r8_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe_o |-> !irq_pad_o);

endmodule

// File: tb/phy_irq_ctrl_tb.sv
`timescale 1ns/1ps
module phy_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  evt = '0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] rdata;
    logic        oe;
    logic        pad;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phy_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_rdata_o (rdata),
        .irq_oe_o    (oe),
        .irq_pad_o   (pad)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [15:0] d);
        addr = a; rd = 1'b1;
        tick();
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [8:0] e);
        evt = e;
        tick();
        evt = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 rdata", rdata, 16'h0);
        chk("R1 oe", {15'h0, oe}, 16'h0);
        reg_read(5'd24, v); chk("R1 mask", v, 16'h0);
        reg_read(5'd25, v); chk("R1 status", v, 16'h0);

        // R4/R5: each source sets its own bit, regardless of a zero mask
        for (int i = 0; i < 9; i++) begin
            pulse(9'(1 << i));
            tick();
            chk("R4 oe masked", {15'h0, oe}, 16'h0);
            reg_read(5'd25, v); chk("R4 bit position", v, 16'(1 << i));
            reg_read(5'd25, v); chk("R5 cleared by read", v, 16'h0);
        end

        // R2/R3/R10/R8: enable sweep over all 512 values with all bits pending
        pulse(9'h1FF);
        for (int m = 0; m < 512; m++) begin
            reg_write(5'd24, 16'hFE00 | 16'(m));
            tick();
            chk("R10 oe follows mask", {15'h0, oe}, {15'h0, (m != 0)});
            if (oe) chk("R8 pad low", {15'h0, pad}, 16'h0);
            reg_read(5'd24, v); chk("R2 mask readback", v, 16'(m));
        end
        reg_read(5'd25, v); chk("R3 sticky through mask sweep", v, 16'h01FF);
        tick();
        chk("R7 release after clear", {15'h0, oe}, 16'h0);

        // R7: one enabled source against each event source, with latency
        for (int j = 0; j < 9; j++) begin
            reg_write(5'd24, 16'(1 << j));
            for (int i = 0; i < 9; i++) begin
                pulse(9'(1 << i));
                chk("R7 not yet driven", {15'h0, oe}, 16'h0);
                tick();
                chk("R7 oe match", {15'h0, oe}, {15'h0, (i == j)});
                reg_read(5'd25, v); chk("R4 latched", v, 16'(1 << i));
                tick();
                chk("R7 released", {15'h0, oe}, 16'h0);
            end
        end

        // R6: event coincident with a status read
        reg_write(5'd24, 16'h0);
        pulse(9'h001);
        addr = 5'd25; rd = 1'b1; evt = 9'h008;
        tick();
        rd = 1'b0; evt = '0;
        chk("R6 returned value excludes new event", rdata, 16'h0001);
        reg_read(5'd25, v); chk("R6 new event kept", v, 16'h0008);

        // R9: ignored writes, unmapped reads
        reg_write(5'd24, 16'h0055);
        pulse(9'h100);
        reg_write(5'd25, 16'hFFFF);
        reg_write(5'd3, 16'h01FF);
        reg_read(5'd24, v); chk("R9 mask untouched", v, 16'h0055);
        reg_read(5'd25, v); chk("R9 status untouched", v, 16'h0100);
        pulse(9'h1FF);
        for (int a = 0; a < 32; a++) begin
            if (a != 24 && a != 25) begin
                reg_read(5'(a), v); chk("R9 unmapped reads zero", v, 16'h0);
            end
        end
        reg_read(5'd25, v); chk("R9 unmapped reads do not clear", v, 16'h01FF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule